// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This block sits beside a processor core. It gathers interrupt requests from a set of sources into a small queue that keeps them in arrival order. When the core's global interrupt-enable flag is set, the block waits a fixed latency and then scans the queue for the entry with the lowest vector number. It then either redirects the program counter to that vector or discards the entry if the source is no longer eligible.

Source `i` owns vector number `i+1`. A smaller vector number means a higher priority. On a jump the block does four things:

- It hands the current program counter to the stack as a return address.
- It pulses a request to clear the global enable flag.
- It loads a new program counter equal to the vector number times a configurable vector size.
- It acknowledges the source so the source can drop its raised flag.

Each jump is also pushed onto a small nesting record, which the core pops when it returns from a handler.

Requests are taken on the rising edge of a source's raised flag. A source that is already queued is not queued again. A discarded entry is not retried until its source raises again.

Top module: `int_dispatch_unit`

## Requirements
- R1: While `gie` is low, no jump is made (`pc_load`, `push_valid`, `gie_clear` and `irq_ack` stay low). Requests are still queued, and `any_pending` shows them.
- R2: With `gie` high and an empty queue, a request whose rising edge is sampled at clock edge N is dispatched at edge N+LATENCY+1. Its output pulses are visible in the cycle after that edge, which is 4 cycles after the rising edge with LATENCY=2.
- R3: Among all queued entries, the one from the lowest source index (vector number index+1) is dispatched first, whatever the arrival order.
- R4: Removing the chosen entry keeps every other queued entry. All of them are dispatched later, each exactly once.
- R5: If the chosen source has its enable low or its raised flag low at dispatch, the entry is removed with no jump and no acknowledge. That source is not dispatched again until its raised flag rises anew.
- R6: A jump produces a single-cycle pulse on `pc_load`, `push_valid` and `gie_clear` together. In that cycle `push_addr` equals `pc_in` and `pc_new` equals (index+1)*VEC_SIZE.
- R7: `irq_ack` is one-hot on the dispatched source in the jump cycle and zero otherwise.
- R8: Each jump raises `nest_depth` by one and sets `nest_top` to the dispatched vector number. A `reti_done` pulse with no jump lowers `nest_depth` by one, but not below zero.
- R9: A jump made when `nest_depth` equals NEST_DEPTH still happens. In that case `nest_err` pulses with it, and `nest_depth` and `nest_top` are left unchanged.
- R10: A source whose raised flag falls and rises again while it is still queued is dispatched only once.
- R11: `any_pending` is high exactly when the queue holds an entry. While it is low no jump occurs, and the latency count restarts from zero.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raised | input | NUM_SRC | Per-source raised flags |
| irq_enable | input | NUM_SRC | Per-source enables |
| gie | input | 1 | Global interrupt enable |
| pc_in | input | PC_W | Current program counter |
| reti_done | input | 1 | Pulse: a handler has returned |
| push_valid | output | 1 | Pulse: push `push_addr` onto the stack |
| push_addr | output | PC_W | Return address |
| gie_clear | output | 1 | Pulse: clear the global enable |
| pc_load | output | 1 | Pulse: load `pc_new` |
| pc_new | output | PC_W | Handler address |
| irq_ack | output | NUM_SRC | Per-source acknowledge pulse |
| any_pending | output | 1 | Queue not empty |
| nest_depth | output | $clog2(NEST_DEPTH+1) | Handlers currently nested |
| nest_top | output | $clog2(NUM_SRC+1) | Vector of innermost handler, 0 when none |
| nest_err | output | 1 | Pulse: jump made with nesting record full |

## Verification
Every source is dispatched alone to measure the exact latency and the arithmetic on `pc_new`. This exposes off-by-one errors in the delay and in the vector scaling.

Three requests arrive in an order opposite to their priority while `gie` is low. This separates a true scan of the queue from first-in service, and shows whether the head-refill keeps all entries.

A masked source, a source whose flag drops before service, and a source re-raised while queued cover the discard and no-duplicate rules. A run of five jumps without returns fills the nesting record and exercises its full boundary.

// File: rtl/int_disp_pkg.sv
package int_disp_pkg;

  // What the dispatch logic does with the entry chosen by the scan
  typedef enum logic [1:0] {
    SVC_IDLE = 2'd0,
    SVC_JUMP = 2'd1,
    SVC_DROP = 2'd2
  } svc_act_e;

endpackage

// File: rtl/int_pend_queue.sv
// Arrival-order queue of source indices with a lowest-index scan.
module int_pend_queue #(
  parameter int NUM_SRC = 8,
  parameter int QDEPTH  = 16,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int PTR_W  = $clog2(QDEPTH),
  localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] raised,
  input  logic               remove,
  output logic [SRC_W-1:0]   sel_src,
  output logic               nonempty
);

  logic [SRC_W-1:0]   slot_q [QDEPTH];
  logic [PTR_W-1:0]   rd_q, rd_n, wr_q, wr_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [NUM_SRC-1:0] inq_q, inq_n;
  logic [NUM_SRC-1:0] latch_q, latch_n;
  logic [NUM_SRC-1:0] raised_q;
  logic [NUM_SRC-1:0] rise, cand, enq_oh;
  logic               enq_v;
  logic [SRC_W-1:0]   enq_src;
  logic               rem_ok;
  logic               found;
  logic [PTR_W-1:0]   best_slot;
  logic [SRC_W-1:0]   best_src;

  // Request capture: new rising edges plus earlier edges not yet queued
  always_comb begin
    rise    = raised & ~raised_q;
    cand    = (latch_q | rise) & ~inq_q;
    enq_v   = 1'b0;
    enq_src = '0;
    enq_oh  = '0;
    if (cnt_q != CNT_W'(QDEPTH)) begin
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (cand[i]) begin
          enq_v   = 1'b1;
          enq_src = SRC_W'(i);
        end
      end
    end
    if (enq_v) enq_oh[enq_src] = 1'b1;
    latch_n = cand & ~enq_oh;
  end

  // Scan the occupied slots, from read pointer onward, for the lowest index
  always_comb begin
    found     = 1'b0;
    best_slot = rd_q;
    best_src  = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      if ((CNT_W'(i) < cnt_q) &&
          (!found || (slot_q[PTR_W'(rd_q + PTR_W'(i))] < best_src))) begin
        found     = 1'b1;
        best_src  = slot_q[PTR_W'(rd_q + PTR_W'(i))];
        best_slot = PTR_W'(rd_q + PTR_W'(i));
      end
    end
  end

  assign rem_ok = remove && found;

  always_comb begin
    rd_n  = rd_q;
    wr_n  = wr_q;
    inq_n = inq_q;
    if (enq_v) begin
      wr_n           = wr_q + 1'b1;
      inq_n[enq_src] = 1'b1;
    end
    if (rem_ok) begin
      rd_n            = rd_q + 1'b1;
      inq_n[best_src] = 1'b0;
    end
    cnt_n = cnt_q + CNT_W'(enq_v) - CNT_W'(rem_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= '0;
      wr_q     <= '0;
      cnt_q    <= '0;
      inq_q    <= '0;
      latch_q  <= '0;
      raised_q <= '0;
    end else begin
      rd_q     <= rd_n;
      wr_q     <= wr_n;
      cnt_q    <= cnt_n;
      inq_q    <= inq_n;
      latch_q  <= latch_n;
      raised_q <= raised;
    end
  end

  // Storage: the write slot is never occupied, so it never equals best_slot
  always_ff @(posedge clk) begin
    if (enq_v)  slot_q[wr_q]      <= enq_src;
    if (rem_ok) slot_q[best_slot] <= slot_q[rd_q];
  end

  assign sel_src  = best_src;
  assign nonempty = (cnt_q != '0);

endmodule

// File: rtl/int_lat_timer.sv
// Counts service opportunities; fires on the LATENCY-th one after arming.
module int_lat_timer #(
  parameter int LATENCY = 2,
  localparam int W      = $clog2(LATENCY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gie,
  input  logic pending,
  output logic fire
);

  logic [W-1:0] wait_q, wait_n;

  always_comb begin
    wait_n = wait_q;
    fire   = 1'b0;
    if (!pending) begin
      wait_n = '0;
    end else if (gie) begin
      if (wait_q == '0) begin
        wait_n = W'(LATENCY);
      end else begin
        wait_n = wait_q - 1'b1;
        fire   = (wait_q == W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= '0;
    else        wait_q <= wait_n;
  end

endmodule

// File: rtl/int_nest_stack.sv
// Record of vectors of handlers currently running.
module int_nest_stack #(
  parameter int NEST_DEPTH = 4,
  parameter int VEC_W      = 4,
  localparam int DW        = $clog2(NEST_DEPTH + 1),
  localparam int IW        = $clog2(NEST_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [VEC_W-1:0] push_vec,
  input  logic             pop,
  output logic [DW-1:0]    depth,
  output logic [VEC_W-1:0] top_vec,
  output logic             overflow
);

  logic [VEC_W-1:0] stk_q [NEST_DEPTH];
  logic [DW-1:0]    depth_q, depth_n;
  logic             ovf_q, ovf_n;
  logic             wr_en;
  logic             full;

  assign full = (depth_q == DW'(NEST_DEPTH));

  always_comb begin
    depth_n = depth_q;
    ovf_n   = 1'b0;
    wr_en   = 1'b0;
    if (push) begin
      if (full) begin
        ovf_n = 1'b1;
      end else begin
        wr_en   = 1'b1;
        depth_n = depth_q + 1'b1;
      end
    end else if (pop && (depth_q != '0)) begin
      depth_n = depth_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      depth_q <= depth_n;
      ovf_q   <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) stk_q[IW'(depth_q)] <= push_vec;
  end

  assign depth    = depth_q;
  assign top_vec  = (depth_q == '0) ? '0 : stk_q[IW'(depth_q - 1'b1)];
  assign overflow = ovf_q;

endmodule

// File: rtl/int_dispatch_unit.sv
module int_dispatch_unit
  import int_disp_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int QDEPTH     = 16,
  parameter int PC_W       = 16,
  parameter int VEC_SIZE   = 2,
  parameter int LATENCY    = 2,
  parameter int NEST_DEPTH = 4,
  localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int VEC_W     = $clog2(NUM_SRC + 1),
  localparam int NEST_DW   = $clog2(NEST_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_raised,
  input  logic [NUM_SRC-1:0] irq_enable,
  input  logic               gie,
  input  logic [PC_W-1:0]    pc_in,
  input  logic               reti_done,
  output logic               push_valid,
  output logic [PC_W-1:0]    push_addr,
  output logic               gie_clear,
  output logic               pc_load,
  output logic [PC_W-1:0]    pc_new,
  output logic [NUM_SRC-1:0] irq_ack,
  output logic               any_pending,
  output logic [NEST_DW-1:0] nest_depth,
  output logic [VEC_W-1:0]   nest_top,
  output logic               nest_err
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic [SRC_W-1:0]   sel_src;
  logic               q_nonempty;
  logic               fire;
  svc_act_e           act;
  logic               jump;
  logic [VEC_W-1:0]   sel_vec;
  logic [PC_W-1:0]    target_pc;
  logic [NUM_SRC-1:0] ack_n;

  int_pend_queue #(
    .NUM_SRC (NUM_SRC),
    .QDEPTH  (QDEPTH)
  ) u_queue (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .raised   (irq_raised),
    .remove   (fire),
    .sel_src  (sel_src),
    .nonempty (q_nonempty)
  );

  int_lat_timer #(
    .LATENCY (LATENCY)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .gie     (gie),
    .pending (q_nonempty),
    .fire    (fire)
  );

  // Decide between a jump and a silent discard for the chosen entry
  always_comb begin
    act = SVC_IDLE;
    if (fire) begin
      act = (irq_enable[sel_src] && irq_raised[sel_src]) ? SVC_JUMP : SVC_DROP;
    end
  end

  assign jump      = (act == SVC_JUMP);
  assign sel_vec   = VEC_W'(sel_src) + 1'b1;
  assign target_pc = PC_W'(sel_vec) * PC_W'(VEC_SIZE);

  always_comb begin
    ack_n = '0;
    if (jump) ack_n[sel_src] = 1'b1;
  end

  int_nest_stack #(
    .NEST_DEPTH (NEST_DEPTH),
    .VEC_W      (VEC_W)
  ) u_nest (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .push     (jump),
    .push_vec (sel_vec),
    .pop      (reti_done),
    .depth    (nest_depth),
    .top_vec  (nest_top),
    .overflow (nest_err)
  );

  // Registered jump outputs
  logic               jump_q;
  logic [PC_W-1:0]    push_addr_q, pc_new_q;
  logic [NUM_SRC-1:0] ack_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      jump_q      <= 1'b0;
      ack_q       <= '0;
      push_addr_q <= '0;
      pc_new_q    <= '0;
    end else begin
      jump_q <= jump;
      ack_q  <= ack_n;
      if (jump) begin
        push_addr_q <= pc_in;
        pc_new_q    <= target_pc;
      end
    end
  end

  assign pc_load     = jump_q;
  assign push_valid  = jump_q;
  assign gie_clear   = jump_q;
  assign push_addr   = push_addr_q;
  assign pc_new      = pc_new_q;
  assign irq_ack     = ack_q;
  assign any_pending = q_nonempty;

endmodule

// File: rtl/int_dispatch_unit_chk.sv
module int_dispatch_unit_chk #(
  parameter int NUM_SRC    = 8,
  parameter int NEST_DEPTH = 4,
  localparam int NEST_DW   = $clog2(NEST_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               gie,
  input logic               pc_load,
  input logic [NUM_SRC-1:0] irq_ack,
  input logic               any_pending,
  input logic [NEST_DW-1:0] nest_depth,
  input logic               nest_err
);

  // R1
  jump_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(gie));

  // R7
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));

  // R7
  ack_with_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> ($countones(irq_ack) == 1));

  // R6
  jump_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);

  // R11
  idle_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pending |=> !pc_load);

  // R2
  new_req_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_pending) |=> !pc_load);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nest_err |-> (nest_depth == NEST_DW'(NEST_DEPTH)));

  // R8
  depth_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !nest_err) |-> (nest_depth == $past(nest_depth) + 1'b1));

endmodule

bind int_dispatch_unit int_dispatch_unit_chk #(
  .NUM_SRC    (NUM_SRC),
  .NEST_DEPTH (NEST_DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gie         (gie),
  .pc_load     (pc_load),
  .irq_ack     (irq_ack),
  .any_pending (any_pending),
  .nest_depth  (nest_depth),
  .nest_err    (nest_err)
);

// File: tb/int_dispatch_unit_test.sv
`timescale 1ns/1ps
module int_dispatch_unit_test;

  localparam int NSRC = 8;
  localparam int PCW  = 16;
  localparam int VSZ  = 2;
  localparam int NDEP = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_raised = '0;
  logic [NSRC-1:0] irq_enable = '1;
  logic            gie = 1'b0;
  logic [PCW-1:0]  pc_in = '0;
  logic            reti_done = 1'b0;
  logic            push_valid, gie_clear, pc_load, any_pending, nest_err;
  logic [PCW-1:0]  push_addr, pc_new;
  logic [NSRC-1:0] irq_ack;
  logic [2:0]      nest_depth;
  logic [3:0]      nest_top;

  always #2.5 clk = ~clk;

  int_dispatch_unit #(
    .NUM_SRC(NSRC), .QDEPTH(16), .PC_W(PCW), .VEC_SIZE(VSZ),
    .LATENCY(2), .NEST_DEPTH(NDEP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .irq_raised(irq_raised), .irq_enable(irq_enable),
    .gie(gie), .pc_in(pc_in), .reti_done(reti_done), .push_valid(push_valid),
    .push_addr(push_addr), .gie_clear(gie_clear), .pc_load(pc_load),
    .pc_new(pc_new), .irq_ack(irq_ack), .any_pending(any_pending),
    .nest_depth(nest_depth), .nest_top(nest_top), .nest_err(nest_err)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ev_cnt = 0;
  int ev_vec [16];
  int ev_pc [16];
  int ev_push [16];
  int ev_ack [16];
  int ev_cyc [16];
  bit ev_side [16];
  bit ev_nerr [16];
  bit auto_gie = 1'b1;
  bit auto_reti = 1'b1;
  bit ret_due = 1'b0;
  bit side_seen = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: sample after the edge, then play the core and the sources
  task automatic tick();
    @(posedge clk);
    #1;
    cyc++;
    if (!pc_load && (push_valid || gie_clear || irq_ack != '0)) side_seen = 1'b1;
    if (pc_load) begin
      if (ev_cnt < 16) begin
        ev_vec[ev_cnt]  = int'(pc_new) / VSZ;
        ev_pc[ev_cnt]   = int'(pc_new);
        ev_push[ev_cnt] = int'(push_addr);
        ev_ack[ev_cnt]  = int'(irq_ack);
        ev_cyc[ev_cnt]  = cyc;
        ev_side[ev_cnt] = push_valid && gie_clear;
        ev_nerr[ev_cnt] = nest_err;
      end
      ev_cnt++;
    end
    reti_done = 1'b0;
    if (ret_due) begin
      ret_due = 1'b0;
      if (auto_reti) reti_done = 1'b1;
      if (auto_gie)  gie = 1'b1;
    end
    if (gie_clear) begin
      gie     = 1'b0;
      ret_due = 1'b1;
    end
    irq_raised = irq_raised & ~irq_ack;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_ev(input int target, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (ev_cnt >= target) break;
      tick();
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R12 reset state
    run(4);
    chk(!pc_load && !push_valid && !gie_clear && irq_ack == '0, "R12 jump outputs", pc_load, 0);
    chk(!any_pending, "R12 any_pending", any_pending, 0);
    chk(nest_depth == 0 && nest_top == 0 && !nest_err, "R12 nesting", nest_depth, 0);
    rst_n = 1'b1;
    run(4);

    // Sweep every source alone: latency, target, push, ack, nesting
    gie = 1'b1;
    for (int s = 0; s < NSRC; s++) begin
      int c0;
      ev_cnt = 0;
      pc_in = PCW'(16'h1000 + s * 3);
      irq_raised[s] = 1'b1;
      c0 = cyc;
      wait_ev(1, 12);
      chk(ev_cnt == 1, "R2 one jump per request", ev_cnt, 1);
      chk(ev_cyc[0] == c0 + 4, "R2 latency", ev_cyc[0] - c0, 4);
      chk(ev_pc[0] == (s + 1) * VSZ, "R6 pc_new", ev_pc[0], (s + 1) * VSZ);
      chk(ev_push[0] == 16'h1000 + s * 3, "R6 push_addr", ev_push[0], 16'h1000 + s * 3);
      chk(ev_side[0], "R6 push and gie_clear pulse", ev_side[0], 1);
      chk(ev_ack[0] == (1 << s), "R7 ack one-hot", ev_ack[0], 1 << s);
      chk(nest_depth == 1 && nest_top == 4'(s + 1), "R8 nest push", nest_top, s + 1);
      run(3);
      chk(nest_depth == 0, "R8 nest pop", nest_depth, 0);
      chk(!any_pending, "R11 queue drained", any_pending, 0);
    end
    chk(!side_seen, "R6 no stray pulses", side_seen, 0);

    // Gie low holds everything; arrival order 6, then 2 and 5 together
    gie = 1'b0;
    ev_cnt = 0;
    irq_raised[6] = 1'b1;
    tick();
    irq_raised[2] = 1'b1;
    irq_raised[5] = 1'b1;
    run(12);
    chk(ev_cnt == 0, "R1 no jump with gie low", ev_cnt, 0);
    chk(any_pending, "R1 requests still queued", any_pending, 1);
    chk(!side_seen, "R1 no stray pulses", side_seen, 0);
    gie = 1'b1;
    wait_ev(3, 60);
    run(4);
    chk(ev_cnt == 3, "R4 all entries served", ev_cnt, 3);
    chk(ev_vec[0] == 3, "R3 first lowest vector", ev_vec[0], 3);
    chk(ev_vec[1] == 6, "R3 second", ev_vec[1], 6);
    chk(ev_vec[2] == 7, "R4 refilled head served", ev_vec[2], 7);
    chk(!any_pending, "R11 empty after drain", any_pending, 0);

    // Masked while queued: source 1 dropped, source 4 served
    gie = 1'b0;
    ev_cnt = 0;
    irq_raised[1] = 1'b1;
    irq_raised[4] = 1'b1;
    tick();
    irq_enable[1] = 1'b0;
    tick();
    gie = 1'b1;
    run(30);
    chk(ev_cnt == 1, "R5 masked source skipped", ev_cnt, 1);
    chk(ev_vec[0] == 5, "R5 remaining source served", ev_vec[0], 5);
    chk(irq_raised[1], "R5 dropped source not acked", irq_raised[1], 1);
    chk(!any_pending, "R5 dropped entry removed", any_pending, 0);
    irq_enable[1] = 1'b1;
    run(20);
    chk(ev_cnt == 1, "R5 no retry without new edge", ev_cnt, 1);
    irq_raised[1] = 1'b0;
    tick();

    // Flag drops before service
    gie = 1'b0;
    ev_cnt = 0;
    irq_raised[3] = 1'b1;
    tick();
    irq_raised[3] = 1'b0;
    tick();
    gie = 1'b1;
    run(20);
    chk(ev_cnt == 0, "R5 dropped flag no jump", ev_cnt, 0);
    chk(!any_pending, "R5 dropped flag removed", any_pending, 0);

    // Re-raise while queued: served once
    gie = 1'b0;
    ev_cnt = 0;
    irq_raised[3] = 1'b1;
    tick();
    irq_raised[3] = 1'b0;
    tick();
    irq_raised[3] = 1'b1;
    tick();
    gie = 1'b1;
    run(30);
    chk(ev_cnt == 1, "R10 single dispatch", ev_cnt, 1);
    chk(ev_vec[0] == 4, "R10 vector", ev_vec[0], 4);
    chk(!any_pending, "R10 no second entry", any_pending, 0);

    // Fill the nesting record without returns
    auto_reti = 1'b0;
    ev_cnt = 0;
    gie = 1'b1;
    for (int k = 0; k < 5; k++) begin
      irq_raised[k] = 1'b1;
      wait_ev(k + 1, 20);
      chk(ev_cnt == k + 1, "R9 jump made", ev_cnt, k + 1);
      if (k < NDEP) begin
        chk(nest_depth == 3'(k + 1), "R8 depth grows", nest_depth, k + 1);
        chk(!ev_nerr[k], "R9 no error below full", ev_nerr[k], 0);
      end else begin
        chk(ev_nerr[k], "R9 error when full", ev_nerr[k], 1);
        chk(ev_pc[k] == 5 * VSZ, "R9 jump still taken", ev_pc[k], 5 * VSZ);
        chk(nest_depth == 3'(NDEP), "R9 depth held", nest_depth, NDEP);
        chk(nest_top == 4'd4, "R9 top unchanged", nest_top, 4);
      end
      run(2);
    end
    for (int k = 0; k < NDEP + 1; k++) begin
      reti_done = 1'b1;
      tick();
    end
    tick();
    chk(nest_depth == 0 && nest_top == 0, "R8 pop stops at zero", nest_depth, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule